// File: doc/BRIEF.md
# Edge/Level Interrupt Capture Bank

This block samples up to 32 asynchronous interrupt request lines and holds each one as a pending bit until it is serviced. Every line has its own sensitivity setting. An edge line records a rising transition and keeps it until software or the arbiter clears it. A level line follows its input: it becomes pending while the input is high and drops when the input goes low. Software cannot clear a level line while the input is still asserted.

A 32-bit register port gives access to the raw pending vector, a mask vector, one configuration word per line, and a software trigger. The configuration word holds a priority, the sensitivity and a fast/normal class bit. The pending, mask, class and priority vectors leave the block as registered outputs and feed a separate priority arbiter. A one-cycle `reeval_o` pulse tells that arbiter to run again. The arbiter can hand back the number of the line it served, which clears that line if it is an edge line.

Top module: `irq_cap_bank`

## Requirements
- R1: After reset, the following hold: every pending bit is 0, every mask bit is 1, every line is in edge mode in the normal class with priority 0, and `reeval_o` is 0.
- R2: An edge-mode line becomes pending on a rising transition of its input. A change applied before clock edge k appears at `pend_o` after edge k+2. The delay comes from two synchroniser flops and the pending register.
- R3: An edge-mode pending bit stays set after its input falls. Only a pending-register write or an arbiter clear removes it.
- R4: A level-mode line is pending while its synchronised input is high. The bit clears on the third clock edge after the input goes low.
- R5: A write to offset 0x00 does pending &= wdata | (input & level). A 0 bit clears that line, except for a level line whose synchronised input is still high. That line stays pending.
- R6: Offset 0x04 is the mask register, where 1 means masked. It reads back as written and appears on `mask_o`. Masking does not stop a line from becoming pending.
- R7: Line i's configuration word sits at offset 0x1C + 4*i. Bits [PRIO_W+1:2] hold the priority, bit 1 is the sensitivity (1 = level, 0 = edge) and bit 0 is the class (1 = fast, 0 = normal). The word reads back with all other bits zero and drives `prio_o` (line i at bits [i*PRIO_W +: PRIO_W]) and `fiq_o[i]`.
- R8: A write to offset 0x9C makes only the lowest-numbered set bit of wdata[NUM_LINES-1:0] pending. Higher bits are ignored, a value with no bit in range does nothing, and a read of 0x9C returns 0.
- R9: A read of any other offset, including a misaligned one or a line number of NUM_LINES or above, returns 0. A write there changes no state. Read data is valid one cycle after the read strobe.
- R10: `reeval_o` is high for exactly one cycle in two cases. The first is the cycle in which a pending bit first appears at `pend_o`. The second is the cycle after a mask write. It stays low while already-pending bits are only held.
- R11: When `ack_valid_i` is high, the pending bit of line `ack_line_i` clears if that line is in edge mode. A level-mode line ignores the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | NUM_LINES | Asynchronous interrupt request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid one cycle after the read strobe |
| ack_valid_i | input | 1 | Arbiter clear request |
| ack_line_i | input | LINE_W | Line number to clear |
| pend_o | output | NUM_LINES | Raw pending vector |
| mask_o | output | NUM_LINES | Mask vector, 1 = masked |
| fiq_o | output | NUM_LINES | Class vector, 1 = fast |
| prio_o | output | NUM_LINES*PRIO_W | Packed per-line priorities |
| reeval_o | output | 1 | One-cycle request for the arbiter to re-evaluate |

## Verification
The bench runs an eight-line configuration and visits every line in both sensitivity modes. It checks the exact cycle in which the pending bit appears. A synchroniser one stage short or long would shift that cycle, and an edge line that followed its input like a level line would drop its bit. The software trigger is tried with every nonzero 8-bit value, so an encoder that picked the highest bit or set several bits would fail. Clearing a level line that is still asserted, either through a pending write or through the arbiter, must leave the bit set; a design that cleared it anyway would lose a live interrupt. Unmapped, misaligned and out-of-range configuration offsets must read as zero and leave the mask, class, priority and pending state unchanged.

// File: rtl/irq_cap_pkg.sv
`timescale 1ns/1ps
package irq_cap_pkg;
  localparam int unsigned OFF_PEND   = 'h00;
  localparam int unsigned OFF_MASK   = 'h04;
  localparam int unsigned OFF_CFG0   = 'h1C;
  localparam int unsigned OFF_SWTRIG = 'h9C;
  localparam int unsigned CFG_STRIDE = 4;
  localparam int unsigned PRIO_LSB   = 2;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PEND,
    ACC_MASK,
    ACC_CFG,
    ACC_SWTRIG
  } acc_kind_e;
endpackage

// File: rtl/irq_cap_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser per request line with a history register for
// rising/falling transition detection in the clock domain.
module irq_cap_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/irq_cap_cfg.sv
`timescale 1ns/1ps
// Mask vector and per-line configuration (priority, sensitivity, class).
module irq_cap_cfg
  import irq_cap_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned PRIO_W    = 5,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned CFG_W    = PRIO_W + PRIO_LSB
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mask_we_i,
  input  logic [NUM_LINES-1:0]        mask_wdata_i,
  input  logic                        cfg_we_i,
  input  logic [LINE_W-1:0]           cfg_line_i,
  input  logic [CFG_W-1:0]            cfg_wdata_i,
  output logic [DATA_W-1:0]           cfg_rdata_o,
  output logic [NUM_LINES-1:0]        mask_o,
  output logic [NUM_LINES-1:0]        level_o,
  output logic [NUM_LINES-1:0]        fiq_o,
  output logic [NUM_LINES*PRIO_W-1:0] prio_o
);
  logic [NUM_LINES-1:0] mask_q, level_q, fiq_q;
  logic [PRIO_W-1:0]    prio_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      level_q <= '0;
      fiq_q   <= '0;
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (cfg_we_i && cfg_line_i == LINE_W'(i)) begin
          prio_q[i]  <= cfg_wdata_i[PRIO_LSB +: PRIO_W];
          level_q[i] <= cfg_wdata_i[1];
          fiq_q[i]   <= cfg_wdata_i[0];
        end
      end
    end
  end

  assign cfg_rdata_o = DATA_W'({prio_q[cfg_line_i], level_q[cfg_line_i], fiq_q[cfg_line_i]});

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_prio
      assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
    end
  endgenerate

  assign mask_o  = mask_q;
  assign level_o = level_q;
  assign fiq_o   = fiq_q;
endmodule

// File: rtl/irq_cap_pend.sv
`timescale 1ns/1ps
// Pending register: set by edge/level capture or software trigger,
// cleared by register write, arbiter clear or level release.
module irq_cap_pend #(
  parameter int unsigned NUM_LINES = 32,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] level_mode_i,
  input  logic [NUM_LINES-1:0] lvl_i,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic [NUM_LINES-1:0] fall_i,
  input  logic                 pend_we_i,
  input  logic [NUM_LINES-1:0] pend_wdata_i,
  input  logic                 sw_we_i,
  input  logic [NUM_LINES-1:0] sw_wdata_i,
  input  logic                 ack_valid_i,
  input  logic [LINE_W-1:0]    ack_line_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 new_set_o
);
  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] sw_set, set_vec, keep, ack_clr, rel_clr;
  logic                 found;

  always_comb begin
    sw_set = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (sw_we_i && !found && sw_wdata_i[i]) begin
        sw_set[i] = 1'b1;
        found     = 1'b1;
      end
    end

    ack_clr = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (ack_valid_i && ack_line_i == LINE_W'(i) && !level_mode_i[i])
        ack_clr[i] = 1'b1;
    end

    set_vec = (rise_i & ~level_mode_i) | (lvl_i & level_mode_i) | sw_set;
    keep    = pend_we_i ? (pend_wdata_i | (lvl_i & level_mode_i)) : '1;
    rel_clr = fall_i & level_mode_i;
    pend_d  = (pend_q & keep & ~ack_clr & ~rel_clr) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  assign pend_o    = pend_q;
  assign new_set_o = |(set_vec & ~pend_q);
endmodule

// File: rtl/irq_cap_bank.sv
`timescale 1ns/1ps
module irq_cap_bank
  import irq_cap_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned PRIO_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LINE_W     = $clog2(NUM_LINES),
  localparam int unsigned CFG_W      = PRIO_W + PRIO_LSB,
  localparam int unsigned CFG_END    = OFF_CFG0 + CFG_STRIDE * NUM_LINES
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        irq_req_i,
  input  logic                        bus_wr_i,
  input  logic                        bus_rd_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [DATA_W-1:0]           bus_wdata_i,
  output logic [DATA_W-1:0]           bus_rdata_o,
  input  logic                        ack_valid_i,
  input  logic [LINE_W-1:0]           ack_line_i,
  output logic [NUM_LINES-1:0]        pend_o,
  output logic [NUM_LINES-1:0]        mask_o,
  output logic [NUM_LINES-1:0]        fiq_o,
  output logic [NUM_LINES*PRIO_W-1:0] prio_o,
  output logic                        reeval_o
);
  logic [31:0]          addr_w;
  acc_kind_e            acc;
  logic [LINE_W-1:0]    cfg_idx;
  logic [NUM_LINES-1:0] lvl, rise, fall, level_mode;
  logic [DATA_W-1:0]    cfg_rdata, rdata_q;
  logic                 mask_we, cfg_we, pend_we, sw_we, new_set, reeval_q;

  assign addr_w = {{(32-ADDR_W){1'b0}}, bus_addr_i};

  always_comb begin
    acc     = ACC_NONE;
    cfg_idx = '0;
    if (addr_w == OFF_PEND)        acc = ACC_PEND;
    else if (addr_w == OFF_MASK)   acc = ACC_MASK;
    else if (addr_w == OFF_SWTRIG) acc = ACC_SWTRIG;
    else if (addr_w >= OFF_CFG0 && addr_w < CFG_END && addr_w[1:0] == 2'b00) begin
      acc     = ACC_CFG;
      cfg_idx = LINE_W'((addr_w - OFF_CFG0) >> 2);
    end
  end

  assign pend_we = bus_wr_i && acc == ACC_PEND;
  assign mask_we = bus_wr_i && acc == ACC_MASK;
  assign cfg_we  = bus_wr_i && acc == ACC_CFG;
  assign sw_we   = bus_wr_i && acc == ACC_SWTRIG;

  irq_cap_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(irq_req_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  irq_cap_cfg #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .mask_we_i   (mask_we),
    .mask_wdata_i(bus_wdata_i[NUM_LINES-1:0]),
    .cfg_we_i    (cfg_we),
    .cfg_line_i  (cfg_idx),
    .cfg_wdata_i (bus_wdata_i[CFG_W-1:0]),
    .cfg_rdata_o (cfg_rdata),
    .mask_o      (mask_o),
    .level_o     (level_mode),
    .fiq_o       (fiq_o),
    .prio_o      (prio_o)
  );

  irq_cap_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk         (clk),
    .rst         (rst),
    .level_mode_i(level_mode),
    .lvl_i       (lvl),
    .rise_i      (rise),
    .fall_i      (fall),
    .pend_we_i   (pend_we),
    .pend_wdata_i(bus_wdata_i[NUM_LINES-1:0]),
    .sw_we_i     (sw_we),
    .sw_wdata_i  (bus_wdata_i[NUM_LINES-1:0]),
    .ack_valid_i (ack_valid_i),
    .ack_line_i  (ack_line_i),
    .pend_o      (pend_o),
    .new_set_o   (new_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      reeval_q <= 1'b0;
    end else begin
      reeval_q <= new_set | mask_we;
      if (bus_rd_i) begin
        case (acc)
          ACC_PEND: rdata_q <= DATA_W'(pend_o);
          ACC_MASK: rdata_q <= DATA_W'(mask_o);
          ACC_CFG:  rdata_q <= cfg_rdata;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata_o = rdata_q;
  assign reeval_o    = reeval_q;
endmodule

// File: rtl/irq_cap_bank_chk.sv
`timescale 1ns/1ps
module irq_cap_bank_chk
  import irq_cap_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] level_mode,
  input logic                 reeval,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 ack_valid
);
  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (pend == '0 && mask == '1 && !reeval));

  a_r10_new_bit_pulses: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && |(pend & ~$past(pend))) |-> reeval);

  a_r10_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && reeval) |->
      ($past(bus_wr && bus_addr == ADDR_W'(OFF_MASK)) || |(pend & ~$past(pend))));

  a_r3_edge_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && |($past(pend) & ~pend & ~$past(level_mode))) |->
      $past(ack_valid || (bus_wr && bus_addr == ADDR_W'(OFF_PEND))));

  a_r6_mask_written: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_MASK)) |=> (mask == $past(bus_wdata[NUM_LINES-1:0])));

  a_r8_trigger_sets: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_SWTRIG) && |bus_wdata[NUM_LINES-1:0]) |=>
      |(pend & $past(bus_wdata[NUM_LINES-1:0])));
endmodule

bind irq_cap_bank irq_cap_bank_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pend      (pend_o),
  .mask      (mask_o),
  .level_mode(level_mode),
  .reeval    (reeval_o),
  .bus_wr    (bus_wr_i),
  .bus_addr  (bus_addr_i),
  .bus_wdata (bus_wdata_i),
  .ack_valid (ack_valid_i)
);

// File: tb/sim_irq_cap_bank.sv
`timescale 1ns/1ps
module sim_irq_cap_bank;
  localparam int N  = 8;
  localparam int PW = 5;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          ack_v = 1'b0;
  logic [LW-1:0] ack_l = '0;
  logic [N-1:0]  pend, mask, fiq;
  logic [N*PW-1:0] prio;
  logic          reeval;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #10 clk = ~clk;

  irq_cap_bank #(.NUM_LINES(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rst(rst), .irq_req_i(req),
    .bus_wr_i(wr_i), .bus_rd_i(rd_i), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ack_valid_i(ack_v), .ack_line_i(ack_l),
    .pend_o(pend), .mask_o(mask), .fiq_o(fiq), .prio_o(prio), .reeval_o(reeval)
  );

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_i = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_i = 1'b1; addr = a;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata;
  endtask

  task automatic ack(logic [LW-1:0] line);
    ack_v = 1'b1; ack_l = line;
    @(negedge clk);
    ack_v = 1'b0;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [N*PW-1:0] exp_prio;
    logic [N-1:0] exp_fiq;

    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    chk("R1 pend", 64'(pend), 64'h0);
    chk("R1 mask", 64'(mask), 64'hFF);
    chk("R1 reeval", 64'(reeval), 64'h0);
    chk("R1 prio", 64'(prio), 64'h0);
    chk("R1 fiq", 64'(fiq), 64'h0);
    rd(8'h04, d); chk("R1 mask read", 64'(d), 64'hFF);
    rd(8'h1C, d); chk("R1 cfg read", 64'(d), 64'h0);

    // R2 R3 R5 R10: edge lines
    for (int i = 0; i < N; i++) begin
      req[i] = 1'b1;
      cyc(2); chk("R2 not yet", 64'(pend), 64'h0);
      cyc(1); chk("R2 edge latch", 64'(pend), 64'(1 << i));
      chk("R10 pulse on new", 64'(reeval), 64'h1);
      cyc(1); chk("R10 one cycle", 64'(reeval), 64'h0);
      req[i] = 1'b0;
      cyc(4); chk("R3 edge sticky", 64'(pend), 64'(1 << i));
      chk("R10 quiet while held", 64'(reeval), 64'h0);
      wr(8'h00, ~(32'h1 << i)); chk("R5 edge clear", 64'(pend), 64'h0);
    end

    // R4 R5: level lines
    for (int i = 0; i < N; i++) begin
      wr(8'(8'h1C + 4*i), 32'h2);
      req[i] = 1'b1;
      cyc(3); chk("R4 level set", 64'(pend), 64'(1 << i));
      wr(8'h00, 32'h0); chk("R5 level clear ignored", 64'(pend), 64'(1 << i));
      req[i] = 1'b0;
      cyc(2); chk("R4 level held in sync", 64'(pend), 64'(1 << i));
      cyc(1); chk("R4 level released", 64'(pend), 64'h0);
      wr(8'(8'h1C + 4*i), 32'h0);
    end

    // R7 configuration words
    exp_prio = '0; exp_fiq = '0;
    for (int i = 0; i < N; i++) begin
      logic [6:0] v;
      v = {5'((i*7 + 3) % 32), 1'((i >> 1) & 1), 1'(i & 1)};
      exp_prio[i*PW +: PW] = 5'((i*7 + 3) % 32);
      exp_fiq[i] = 1'(i & 1);
      wr(8'(8'h1C + 4*i), 32'hFFFF_FF80 | 32'(v));
      rd(8'(8'h1C + 4*i), d);
      chk("R7 cfg readback", 64'(d), 64'(v));
    end
    chk("R7 prio vector", 64'(prio), 64'(exp_prio));
    chk("R7 fiq vector", 64'(fiq), 64'(exp_fiq));
    for (int i = 0; i < N; i++) wr(8'(8'h1C + 4*i), 32'h0);
    chk("R7 cfg cleared", 64'(prio), 64'h0);

    // R6 R10 mask
    wr(8'h04, 32'h5A);
    chk("R6 mask out", 64'(mask), 64'h5A);
    chk("R10 pulse on mask write", 64'(reeval), 64'h1);
    cyc(1); chk("R10 mask pulse ends", 64'(reeval), 64'h0);
    rd(8'h04, d); chk("R6 mask read", 64'(d), 64'h5A);
    wr(8'h9C, 32'h02); chk("R6 masked still pends", 64'(pend), 64'h02);
    wr(8'h00, 32'h0);

    // R8 software trigger, every nonzero value
    for (int v = 1; v < 256; v++) begin
      wr(8'h9C, 32'(v));
      chk("R8 lowest bit", 64'(pend), 64'(v & -v));
      chk("R10 pulse on trigger", 64'(reeval), 64'h1);
      wr(8'h00, 32'h0);
      chk("R5 clear after trigger", 64'(pend), 64'h0);
    end
    wr(8'h9C, 32'hFFFF_FF00); chk("R8 out of range ignored", 64'(pend), 64'h0);
    wr(8'h9C, 32'h04);
    rd(8'h9C, d); chk("R8 reads zero", 64'(d), 64'h0);
    wr(8'h9C, 32'h04); chk("R10 no pulse if already pending", 64'(reeval), 64'h0);

    // R9 unmapped offsets
    begin
      logic [7:0] bad [7] = '{8'h08, 8'h0C, 8'h10, 8'h3C, 8'hA0, 8'hFC, 8'h1D};
      for (int k = 0; k < 7; k++) begin
        wr(bad[k], 32'hFFFF_FFFF);
        rd(bad[k], d);
        chk("R9 unmapped reads zero", 64'(d), 64'h0);
      end
    end
    chk("R9 pend untouched", 64'(pend), 64'h04);
    chk("R9 mask untouched", 64'(mask), 64'h5A);
    chk("R9 prio untouched", 64'(prio), 64'h0);
    chk("R9 fiq untouched", 64'(fiq), 64'h0);
    rd(8'h00, d); chk("R9 pend read", 64'(d), 64'h04);

    // R11 arbiter clear
    ack(3'd2); chk("R11 edge ack clears", 64'(pend), 64'h0);
    wr(8'h28, 32'h2);
    req[3] = 1'b1;
    cyc(3); chk("R11 level set", 64'(pend), 64'h08);
    ack(3'd3); chk("R11 level ack ignored", 64'(pend), 64'h08);
    req[3] = 1'b0;
    cyc(4); chk("R4 level drop", 64'(pend), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule